// File: doc/BRIEF.md
# Test Vector Hit Tracker

This block watches the patterns a self-test generator applies to a core and compares each one against a fixed set of N reference vectors of K bits each. Any bit of a reference vector may be a don't-care. The block keeps a sticky bitmap of the vectors that have been hit and a running count of them. A single pattern can hit several vectors, and all of them are recorded in the same cycle.

It also counts self-test clock cycles from the moment the block is cleared. This count includes the cycles spent loading seeds, when no pattern is valid. The count freezes once every vector has been hit, so it then reads the test length. Two flags report full coverage and whether the coverage target has been met.

The reference set is fixed by parameters. Each vector is held as a value word and a care mask. Vector i occupies bits [i*K +: K] of both packed parameters.

Top module: `hit_tracker`

## Requirements
- R1: Vector i matches the applied pattern p exactly when ((p XOR value_i) AND care_i) == 0. A care bit of 0 marks a don't-care, and that position matches either applied value. The matching hit shows in `hit_map_o[i]` after the clock edge that samples the valid pattern.
- R2: Every vector that matches one valid pattern is marked in the same cycle, however many there are.
- R3: Hit bits are sticky until a clear. A vector that is matched again is not counted twice, and `hit_cnt_o` always equals the number of set bits in `hit_map_o`.
- R4: A pattern presented while `pat_valid_i` is low has no effect on the bitmap or on the hit count.
- R5: After a clear or reset, `cycle_cnt_o` rises by one on every clock edge, whether or not a pattern is valid, for as long as not all vectors are hit. This includes the edge that records the last missing vector. The counter saturates at its maximum value.
- R6: `all_hit_o` is high exactly when all N bitmap bits are set. From then on `cycle_cnt_o` holds its value until the next clear.
- R7: `target_met_o` is high exactly when 10 × hit count > 9 × N, so that a coverage of exactly 90 % does not meet the target.
- R8: Synchronous reset `rst` and `clear_i` both zero the bitmap, the hit count and the cycle count. `clear_i` takes priority over a valid pattern in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Start a new run: clears all state |
| pat_valid_i | input | 1 | Applied pattern is valid this cycle |
| pat_i | input | K | Applied pattern |
| hit_map_o | output | N | Per-vector sticky hit flags |
| hit_cnt_o | output | $clog2(N+1) | Number of distinct vectors hit |
| cycle_cnt_o | output | CW | Clock cycles since clear, frozen at full coverage |
| all_hit_o | output | 1 | Every vector has been hit |
| target_met_o | output | 1 | Coverage is strictly above 90 % |

## Verification
Two functions can fall on the same edge. In the first, the pattern that supplies the last missing vector is also the last pattern the cycle counter counts before it freezes. The bench provokes this by completing the set with a directed pattern and then idling, and it expects the count to include that edge and stay constant afterwards. In the second, a clear arrives in the same cycle as a pattern that matches several vectors. The bench expects everything to read zero afterwards, because clear wins.

// File: rtl/tracker_pkg.sv
package tracker_pkg;

    localparam int unsigned DEF_K   = 10;
    localparam int unsigned DEF_N   = 18;
    localparam int unsigned COV_NUM = 9;
    localparam int unsigned COV_DEN = 10;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_SAMPLE = 2'd1,
        OP_CLEAR  = 2'd2
    } track_op_e;

    // Strictly above COV_NUM/COV_DEN of the total, in integers.
    function automatic logic coverage_met(input int unsigned hits,
                                          input int unsigned total);
        return (COV_DEN * hits) > (COV_NUM * total);
    endfunction

    function automatic logic [DEF_N*DEF_K-1:0] def_values();
        logic [DEF_N*DEF_K-1:0] r;
        r = '0;
        for (int i = 0; i < int'(DEF_N); i++) begin
            r[i*DEF_K +: DEF_K] = DEF_K'((i * 97 + 13) % 1024);
        end
        return r;
    endfunction

    function automatic logic [DEF_N*DEF_K-1:0] def_cares();
        logic [DEF_N*DEF_K-1:0] r;
        logic [DEF_K-1:0]       m;
        r = '0;
        for (int i = 0; i < int'(DEF_N); i++) begin
            m = '1;
            m[i % int'(DEF_K)] = 1'b0;
            if (i % 3 == 0) m[DEF_K-1] = 1'b0;
            r[i*DEF_K +: DEF_K] = m;
        end
        return r;
    endfunction

endpackage

// File: rtl/vec_matcher.sv
module vec_matcher #(
    parameter int unsigned K = 10,
    parameter int unsigned N = 18
) (
    input  logic [K-1:0]   pat,
    input  logic           sample,
    input  logic [N*K-1:0] vals,
    input  logic [N*K-1:0] cares,
    output logic [N-1:0]   match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [K-1:0] diff;
        assign diff     = (pat ^ vals[g*K +: K]) & cares[g*K +: K];
        assign match[g] = sample & (diff == '0);
    end
endmodule

// File: rtl/hit_register.sv
module hit_register
    import tracker_pkg::*;
#(
    parameter int unsigned N     = 18,
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  track_op_e        op,
    input  logic [N-1:0]     new_hits,
    output logic [N-1:0]     hit_map,
    output logic [CNT_W-1:0] hit_cnt
);
    logic [N-1:0]     map_nxt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        unique case (op)
            OP_CLEAR:  map_nxt = '0;
            OP_SAMPLE: map_nxt = hit_map | new_hits;
            default:   map_nxt = hit_map;
        endcase
        cnt_nxt = '0;
        for (int i = 0; i < int'(N); i++) begin
            cnt_nxt = cnt_nxt + CNT_W'(map_nxt[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_map <= '0;
            hit_cnt <= '0;
        end else begin
            hit_map <= map_nxt;
            hit_cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter
    import tracker_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  track_op_e     op,
    input  logic          done,
    output logic [CW-1:0] cnt
);
    logic at_max;
    assign at_max = (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst || op == OP_CLEAR) begin
            cnt <= '0;
        end else if (!done && !at_max) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hit_tracker.sv
module hit_tracker
    import tracker_pkg::*;
#(
    parameter int unsigned    K     = DEF_K,
    parameter int unsigned    N     = DEF_N,
    parameter int unsigned    CW    = 16,
    parameter logic [N*K-1:0] VEC_VAL  = def_values(),
    parameter logic [N*K-1:0] VEC_CARE = def_cares(),
    localparam int unsigned   CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             pat_valid_i,
    input  logic [K-1:0]     pat_i,
    output logic [N-1:0]     hit_map_o,
    output logic [CNT_W-1:0] hit_cnt_o,
    output logic [CW-1:0]    cycle_cnt_o,
    output logic             all_hit_o,
    output logic             target_met_o
);
    track_op_e    op;
    logic [N-1:0] match;

    always_comb begin
        if (clear_i)          op = OP_CLEAR;
        else if (pat_valid_i) op = OP_SAMPLE;
        else                  op = OP_IDLE;
    end

    vec_matcher #(.K(K), .N(N)) i_match (
        .pat    (pat_i),
        .sample (pat_valid_i),
        .vals   (VEC_VAL),
        .cares  (VEC_CARE),
        .match  (match)
    );

    hit_register #(.N(N), .CNT_W(CNT_W)) i_hits (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .new_hits (match),
        .hit_map  (hit_map_o),
        .hit_cnt  (hit_cnt_o)
    );

    assign all_hit_o    = &hit_map_o;
    assign target_met_o = coverage_met(int'(hit_cnt_o), N);

    cycle_counter #(.CW(CW)) i_cyc (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .done (all_hit_o),
        .cnt  (cycle_cnt_o)
    );
endmodule

// File: rtl/hit_tracker_chk.sv
module hit_tracker_chk #(
    parameter int unsigned N     = 18,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned CW    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             clear_i,
    input logic             pat_valid_i,
    input logic [N-1:0]     hit_map_o,
    input logic [CNT_W-1:0] hit_cnt_o,
    input logic [CW-1:0]    cycle_cnt_o,
    input logic             all_hit_o,
    input logic             target_met_o
);
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((hit_map_o & $past(hit_map_o)) == $past(hit_map_o)));

    p_count_r3: assert property (@(posedge clk) disable iff (rst)
        32'(hit_cnt_o) == $countones(hit_map_o));

    p_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!pat_valid_i && !clear_i) |=> $stable(hit_map_o));

    p_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && !all_hit_o && cycle_cnt_o != '1)
            |=> cycle_cnt_o == CW'($past(cycle_cnt_o) + 1'b1));

    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (all_hit_o && !clear_i) |=> $stable(cycle_cnt_o));

    p_full_target_r7: assert property (@(posedge clk) disable iff (rst)
        all_hit_o |-> target_met_o);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (hit_map_o == '0 && cycle_cnt_o == '0));
endmodule

bind hit_tracker hit_tracker_chk #(.N(N), .CNT_W(CNT_W), .CW(CW)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (clear_i),
    .pat_valid_i  (pat_valid_i),
    .hit_map_o    (hit_map_o),
    .hit_cnt_o    (hit_cnt_o),
    .cycle_cnt_o  (cycle_cnt_o),
    .all_hit_o    (all_hit_o),
    .target_met_o (target_met_o)
);

// File: tb/test_hit_tracker.sv
module test_hit_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int TK  = 8;
    localparam int TN  = 10;
    localparam int TCW = 16;
    localparam int TCNT_W = $clog2(TN + 1);

    localparam logic [7:0] TV_VAL  [TN] = '{8'hA5, 8'hA0, 8'h0F, 8'h30, 8'hC3,
                                            8'h5A, 8'h66, 8'h18, 8'hFE, 8'h00};
    localparam logic [7:0] TV_CARE [TN] = '{8'hFF, 8'hF0, 8'hFF, 8'hF0, 8'hFF,
                                            8'hFF, 8'hFF, 8'h3C, 8'hFF, 8'h00};

    function automatic logic [TN*TK-1:0] pack(input logic [7:0] a [TN]);
        logic [TN*TK-1:0] r;
        for (int i = 0; i < TN; i++) r[i*TK +: TK] = a[i];
        return r;
    endfunction

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              pv  = 1'b0;
    logic [TK-1:0]     pat = '0;
    logic [TN-1:0]     hit_map;
    logic [TCNT_W-1:0] hit_cnt;
    logic [TCW-1:0]    cyc;
    logic              all_hit;
    logic              tgt;

    hit_tracker #(.K(TK), .N(TN), .CW(TCW),
                  .VEC_VAL(pack(TV_VAL)), .VEC_CARE(pack(TV_CARE))) i_hit_tracker (
        .clk(clk), .rst(rst), .clear_i(clr), .pat_valid_i(pv), .pat_i(pat),
        .hit_map_o(hit_map), .hit_cnt_o(hit_cnt), .cycle_cnt_o(cyc),
        .all_hit_o(all_hit), .target_met_o(tgt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [TN-1:0] exp_map = '0;
    int unsigned   exp_cyc = 0;

    function automatic logic [TN-1:0] model_match(input logic [7:0] p);
        logic [TN-1:0] m;
        for (int i = 0; i < TN; i++) m[i] = (((p ^ TV_VAL[i]) & TV_CARE[i]) == 8'h00);
        return m;
    endfunction

    function automatic int popc(input logic [TN-1:0] m);
        int c = 0;
        for (int i = 0; i < TN; i++) c += int'(m[i]);
        return c;
    endfunction

    task automatic chk(input string req, input logic ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1/R2 hit map", hit_map == exp_map, longint'(hit_map), longint'(exp_map));
        chk("R3 hit count", int'(hit_cnt) == popc(exp_map), longint'(hit_cnt), longint'(popc(exp_map)));
        chk("R5 cycle count", int'(cyc) == int'(exp_cyc), longint'(cyc), longint'(exp_cyc));
        chk("R6 all hit", all_hit == (&exp_map), longint'(all_hit), longint'(&exp_map));
        chk("R7 target", tgt == (10 * popc(exp_map) > 9 * TN), longint'(tgt),
            longint'(10 * popc(exp_map) > 9 * TN));
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic v, input logic [7:0] p, input logic c);
        pv = v; pat = p; clr = c;
        @(posedge clk);
        if (c) begin
            exp_map = '0;
            exp_cyc = 0;
        end else begin
            if (!(&exp_map)) exp_cyc++;
            if (v) exp_map = exp_map | model_match(p);
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rp;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1d2c3b4a);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        compare_all();
        chk("R8 reset map", hit_map == '0, longint'(hit_map), 0);

        // R4: matching pattern with valid low
        step(1'b0, 8'hA5, 1'b0);
        chk("R4 invalid ignored", hit_cnt == '0, longint'(hit_cnt), 0);
        // R5: idle seed-load cycles still counted
        step(1'b0, 8'h00, 1'b0);
        chk("R5 idle cycles counted", cyc == 16'd2, longint'(cyc), 2);

        // R2: one pattern hits vectors 0, 1 and 9
        step(1'b1, 8'hA5, 1'b0);
        chk("R2 multi hit", hit_map == 10'b10_0000_0011, longint'(hit_map), 10'h203);
        // R3: repeat does not recount
        step(1'b1, 8'hA5, 1'b0);
        chk("R3 no recount", hit_cnt == 4'd3, longint'(hit_cnt), 3);

        // R1: don't-care low nibble of vector 1
        step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'hA7, 1'b0);
        chk("R1 dont care", hit_map == 10'b10_0000_0010, longint'(hit_map), 10'h202);

        // R7: nine of ten hit is exactly 90 percent, not met
        for (int i = 0; i < 8; i++) step(1'b1, TV_VAL[i], 1'b0);
        chk("R7 at 90 percent", hit_cnt == 4'd9 && tgt == 1'b0, longint'({hit_cnt, tgt}), 32'h12);
        // R6: last vector, then frozen counter
        step(1'b1, 8'hFE, 1'b0);
        chk("R6 full", all_hit == 1'b1 && tgt == 1'b1, longint'({all_hit, tgt}), 3);
        chk("R5 count includes last edge", int'(cyc) == 10, longint'(cyc), 10);
        for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b0);
        chk("R6 frozen", int'(cyc) == 10, longint'(cyc), 10);

        // R8: clear beats a valid multi-hit pattern
        step(1'b1, 8'hA5, 1'b1);
        chk("R8 clear priority", hit_map == '0 && cyc == '0, longint'({hit_map, cyc}), 0);

        // Random mix
        for (int t = 0; t < 600; t++) begin
            if ($urandom_range(1, 2) == 1) rp = 8'($urandom);
            else begin
                int j = int'($urandom_range(0, TN - 1));
                rp = TV_VAL[j] ^ (8'($urandom) & ~TV_CARE[j]);
            end
            step($urandom_range(0, 3) != 0, rp, $urandom_range(0, 59) == 0);
        end

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule